// File: doc/BRIEF.md
# Late Branch Resolution and Squash Controller

This block handles control hazards for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which a conditional branch learns its outcome only when it reaches the memory stage. It owns the fetch address register. It carries each instruction's valid bit, branch flag and branch operands alongside the pipeline. It then decides, cycle by cycle, where the next fetch comes from and which in-flight instructions must become bubbles. The register file, ALU and memories live elsewhere. The surrounding pipeline tells the block when the instruction in decode is an equality branch and gives its 16-bit offset. It also supplies the ALU zero flag of the instruction in execute.

A mode input picks one of two policies. In squash-on-taken mode, fetch runs ahead sequentially. A taken branch then wipes the three younger instructions that followed it, and a not-taken branch costs nothing. In hold-after-branch mode, fetch freezes as soon as a branch is decoded. It resumes from the resolved address once the branch reaches the memory stage, so every branch costs a fixed three cycles. The wrong-path instruction that was already fetched behind the branch is discarded.

Top module: `branch_squash_ctl`

## Requirements
- R1: While `rst` is high, at the next clock edge `fetchPc` becomes 0 and all four stage valid outputs clear. With no valid branch in flight, `pcSel` is 0 and all three kill outputs are low.
- R2: The branch target is the branch's own address plus 4, plus the sign-extended offset shifted left by two. A branch at 40 with offset 7 targets 72, and a branch at 60 with offset -5 targets 44.
- R3: In squash-on-taken mode, a valid branch whose zero flag was 1 in execute redirects `fetchPc` to the target on the edge that ends its memory cycle. None of the three sequential instructions after it ever reaches writeback with its valid bit set. The target instruction retires exactly 4 cycles after the branch.
- R4: `pcSel` encodes the fetch source as 0 for sequential, 1 for hold, 2 for branch target and 3 for branch fall-through. In the cycle a taken branch resolves, `pcSel` is 2 and `killFetch`, `killDecode` and `killExecute` are all 1.
- R5: In squash-on-taken mode, a branch whose zero flag was 0 inserts no bubble: the instructions after it retire on consecutive cycles, and `pcSel` never shows 1, 2 or 3 for it.
- R6: In hold-after-branch mode, `pcSel` is 1 and `fetchPc` holds while a valid branch is in decode or execute. The instruction in fetch is killed while a valid branch is in decode, execute or memory.
- R7: In hold-after-branch mode, a branch's memory cycle shows `pcSel` 2 if taken, loading the target, or 3 if not, loading the branch address plus 4. The next instruction retires exactly 4 cycles after the branch in both cases.
- R8: An instruction whose valid bit has been cleared never redirects fetch, never holds it and never raises a kill, even when it is a branch.
- R9: Branches resolve in program order. An older taken branch cancels a younger branch right behind it. An older not-taken branch lets the younger one resolve normally, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stallMode | input | 1 | 1 selects hold-after-branch, 0 selects squash-on-taken |
| decIsBranch | input | 1 | Instruction in decode is a conditional equality branch |
| decOffset | input | OFF_W | Word offset field of the instruction in decode |
| exZero | input | 1 | ALU zero flag of the instruction in execute |
| fetchPc | output | ADDR_W | Address being fetched this cycle |
| pcSel | output | 2 | Fetch source for the next cycle (encoding in R4) |
| branchTarget | output | ADDR_W | Target of the instruction in the memory stage |
| killFetch | output | 1 | Instruction in fetch becomes a bubble |
| killDecode | output | 1 | Instruction in decode becomes a bubble |
| killExecute | output | 1 | Instruction in execute becomes a bubble |
| vldDecode | output | 1 | Decode-stage valid bit |
| vldExecute | output | 1 | Execute-stage valid bit |
| vldMemory | output | 1 | Memory-stage valid bit; gates data-memory writes |
| vldWriteback | output | 1 | Writeback-stage valid bit; gates register-file writes |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 16-bit offset and 4-byte instructions. With these values the two-bit offset shift and the sign extension of a negative offset both show up in real target addresses, such as 72 and 44, that a short program starting at 0 reaches in a few dozen cycles. A small pipeline shell in the bench follows each fetched address down the stages and records which addresses retire and in which cycle. It checks both modes with taken, not-taken and back-to-back branches by the retire order and the cycle gaps around each branch.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // Fetch source for the next cycle; the code values are visible on pcSel.
  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_HOLD   = 2'd1,
    PC_TARGET = 2'd2,
    PC_FALL   = 2'd3
  } pcSrc_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic holdPc;
    logic loadTarget;
    logic loadFall;
  } pcStrobe_t;

endpackage

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobe_t         strobe,
  input  logic [OFF_W-1:0]  decOffset,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] branchTarget
);

  localparam int SHIFT = $clog2(INSTR_BYTES);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] linkDec, linkExe, linkMem;
  logic [OFF_W-1:0]  offExe, offMem;
  logic [ADDR_W-1:0] offWide;
  logic [ADDR_W-1:0] pcNext;

  assign seqPc   = pcQ + STEP;
  assign offWide = {{EXT_W{offMem[OFF_W-1]}}, offMem};
  assign branchTarget = linkMem + (offWide << SHIFT);
  assign fetchPc = pcQ;

  always_comb begin
    if (strobe.loadTarget)    pcNext = branchTarget;
    else if (strobe.loadFall) pcNext = linkMem;
    else if (strobe.holdPc)   pcNext = pcQ;
    else                      pcNext = seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= '0;
      linkDec <= '0;
      linkExe <= '0;
      linkMem <= '0;
      offExe  <= '0;
      offMem  <= '0;
    end else begin
      pcQ     <= pcNext;
      linkDec <= seqPc;
      linkExe <= linkDec;
      linkMem <= linkExe;
      offExe  <= decOffset;
      offMem  <= offExe;
    end
  end

  // R1: reset vector
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pcQ == '0));
  // R2: a taken redirect lands on the computed target
  a_r2_target_load: assert property (@(posedge clk) disable iff (rst)
    strobe.loadTarget |=> (pcQ == $past(branchTarget)));
  // R7: a not-taken resolution in hold mode resumes at branch+step
  a_r7_fall_load: assert property (@(posedge clk) disable iff (rst)
    strobe.loadFall |=> (pcQ == $past(linkMem)));
  // R6: the fetch address does not move while held
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    strobe.holdPc |=> $stable(pcQ));
  // R4: one fetch source at a time
  a_r4_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.holdPc, strobe.loadTarget, strobe.loadFall}));

endmodule

// File: rtl/bsc_control.sv
module bsc_control
  import bsc_pkg::*;
#(
  parameter int N_STAGE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stallMode,
  input  logic               decIsBranch,
  input  logic               exZero,
  output pcStrobe_t          strobe,
  output pcSrc_e             pcSel,
  output logic               killFetch,
  output logic               killDecode,
  output logic               killExecute,
  output logic [N_STAGE-1:0] vldQ
);

  localparam int S_DEC = 0;
  localparam int S_EXE = 1;
  localparam int S_MEM = 2;
  localparam int S_WB  = N_STAGE - 1;

  logic brExe, brMem, zeroMem;
  logic decBr, exeBr, memBr, memTaken;
  logic [N_STAGE-1:0] clrVec;

  // Only an instruction whose valid bit is set may act as a branch.
  assign decBr    = vldQ[S_DEC] & decIsBranch;
  assign exeBr    = vldQ[S_EXE] & brExe;
  assign memBr    = vldQ[S_MEM] & brMem;
  assign memTaken = memBr & zeroMem;

  always_comb begin
    killDecode  = memTaken;
    killExecute = memTaken;
    if (stallMode) begin
      killFetch = decBr | exeBr | memBr;
      if (memBr)               pcSel = zeroMem ? PC_TARGET : PC_FALL;
      else if (decBr | exeBr)  pcSel = PC_HOLD;
      else                     pcSel = PC_SEQ;
    end else begin
      killFetch = memTaken;
      pcSel     = memTaken ? PC_TARGET : PC_SEQ;
    end
    strobe.holdPc     = (pcSel == PC_HOLD);
    strobe.loadTarget = (pcSel == PC_TARGET);
    strobe.loadFall   = (pcSel == PC_FALL);
  end

  always_comb begin
    clrVec        = '0;
    clrVec[S_DEC] = killFetch;
    clrVec[S_EXE] = killDecode;
    clrVec[S_MEM] = killExecute;
  end

  // Valid chain: each stage takes the previous one unless killed.
  for (genvar s = 0; s < N_STAGE; s++) begin : g_vld
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vldQ[s] <= 1'b0;
        else     vldQ[s] <= ~clrVec[s];
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) vldQ[s] <= 1'b0;
        else     vldQ[s] <= vldQ[s-1] & ~clrVec[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brExe   <= 1'b0;
      brMem   <= 1'b0;
      zeroMem <= 1'b0;
    end else begin
      brExe   <= decIsBranch;
      brMem   <= brExe;
      zeroMem <= exZero;
    end
  end

  // R1: reset empties the pipe
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (vldQ == '0) && (pcSel == PC_SEQ) && !killFetch);
  // R3: after a taken branch retires, three bubbles follow in writeback
  a_r3_wb_bubbles: assert property (@(posedge clk) disable iff (rst)
    memTaken |=> vldQ[S_WB] ##1 !vldQ[S_WB] ##1 !vldQ[S_WB] ##1 !vldQ[S_WB]);
  // R5: a not-taken branch in squash mode lets its follower advance
  a_r5_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (!stallMode && memBr && !zeroMem && vldQ[S_EXE]) |=> vldQ[S_MEM]);
  // R6: hold mode admits nothing new for three cycles after a decode
  a_r6_fetch_quiet: assert property (@(posedge clk) disable iff (rst)
    (stallMode && decBr) |=> !vldQ[S_DEC] ##1 !vldQ[S_DEC] ##1 !vldQ[S_DEC]);
  // R8: a bubble in memory never redirects or kills
  a_r8_bubble_inert: assert property (@(posedge clk) disable iff (rst)
    !vldQ[S_MEM] |-> ((pcSel == PC_SEQ) || (pcSel == PC_HOLD)) && !killDecode && !killExecute);

endmodule

// File: rtl/branch_squash_ctl.sv
module branch_squash_ctl
  import bsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stallMode,
  input  logic              decIsBranch,
  input  logic [OFF_W-1:0]  decOffset,
  input  logic              exZero,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [1:0]        pcSel,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              killFetch,
  output logic              killDecode,
  output logic              killExecute,
  output logic              vldDecode,
  output logic              vldExecute,
  output logic              vldMemory,
  output logic              vldWriteback
);

  localparam int N_STAGE = 4;

  pcStrobe_t          strobe;
  pcSrc_e             selInt;
  logic [N_STAGE-1:0] vldVec;

  bsc_control #(.N_STAGE(N_STAGE)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .stallMode   (stallMode),
    .decIsBranch (decIsBranch),
    .exZero      (exZero),
    .strobe      (strobe),
    .pcSel       (selInt),
    .killFetch   (killFetch),
    .killDecode  (killDecode),
    .killExecute (killExecute),
    .vldQ        (vldVec)
  );

  bsc_datapath #(
    .ADDR_W      (ADDR_W),
    .OFF_W       (OFF_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .decOffset    (decOffset),
    .fetchPc      (fetchPc),
    .branchTarget (branchTarget)
  );

  assign pcSel        = selInt;
  assign vldDecode    = vldVec[0];
  assign vldExecute   = vldVec[1];
  assign vldMemory    = vldVec[2];
  assign vldWriteback = vldVec[3];

endmodule

// File: tb/sim_branch_squash_ctl.sv
`timescale 1ns/1ps
module sim_branch_squash_ctl;
  localparam int AW = 32;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stallMode = 1'b0;
  logic decIsBranch, exZero;
  logic [OW-1:0] decOffset;
  logic [AW-1:0] fetchPc, branchTarget;
  logic [1:0] pcSel;
  logic killFetch, killDecode, killExecute;
  logic vldDecode, vldExecute, vldMemory, vldWriteback;

  always #2 clk = ~clk;

  branch_squash_ctl u0 (
    .clk(clk), .rst(rst), .stallMode(stallMode), .decIsBranch(decIsBranch),
    .decOffset(decOffset), .exZero(exZero), .fetchPc(fetchPc), .pcSel(pcSel),
    .branchTarget(branchTarget), .killFetch(killFetch), .killDecode(killDecode),
    .killExecute(killExecute), .vldDecode(vldDecode), .vldExecute(vldExecute),
    .vldMemory(vldMemory), .vldWriteback(vldWriteback)
  );

  // Program: up to two branches, all other addresses are plain instructions.
  logic [AW-1:0] brAt0 = '1, brAt1 = '1;
  logic [OW-1:0] brOff0 = '0, brOff1 = '0;
  logic brTk0 = 1'b0, brTk1 = 1'b0;

  // Pipeline shell: address of the instruction in each stage.
  logic [AW-1:0] pcD = '0, pcE = '0, pcM = '0, pcW = '0;
  int cyc = 0;

  always @(posedge clk) begin
    pcD <= fetchPc;
    pcE <= pcD;
    pcM <= pcE;
    pcW <= pcM;
    cyc <= cyc + 1;
  end

  always_comb begin
    decIsBranch = (pcD == brAt0) || (pcD == brAt1);
    decOffset   = (pcD == brAt0) ? brOff0 : brOff1;
    exZero      = (pcE == brAt0) ? brTk0 : ((pcE == brAt1) ? brTk1 : 1'b0);
  end

  // Observation log
  logic [AW-1:0] retPc [64];
  int retCyc [64];
  int retCnt = 0, tgtCnt = 0, holdCnt = 0, fallCnt = 0;
  logic [AW-1:0] resTgt = '0;
  logic [2:0] resKills = '0;
  bit seenRes = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (vldWriteback && retCnt < 64) begin
        retPc[retCnt]  = pcW;
        retCyc[retCnt] = cyc;
        retCnt++;
      end
      if (pcSel == 2'd2) begin
        tgtCnt++;
        if (!seenRes) begin
          seenRes  = 1;
          resTgt   = branchTarget;
          resKills = {killFetch, killDecode, killExecute};
        end
      end
      if (pcSel == 2'd1) holdCnt++;
      if (pcSel == 2'd3) fallCnt++;
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runProg(input bit mode,
                         input logic [AW-1:0] a0, input logic [OW-1:0] o0, input bit t0,
                         input logic [AW-1:0] a1, input logic [OW-1:0] o1, input bit t1);
    @(negedge clk);
    rst = 1'b1;
    stallMode = mode;
    brAt0 = a0; brOff0 = o0; brTk0 = t0;
    brAt1 = a1; brOff1 = o1; brTk1 = t1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    retCnt = 0; tgtCnt = 0; holdCnt = 0; fallCnt = 0;
    seenRes = 0; resTgt = '0; resKills = '0;
    rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 fetchPc", fetchPc, 0);
    chk("R1 valid bits", {vldDecode, vldExecute, vldMemory, vldWriteback}, 0);
    chk("R1 pcSel", pcSel, 0);
    chk("R1 kills", {killFetch, killDecode, killExecute}, 0);
  endtask

  task automatic testNullifyTaken();
    runProg(0, 40, 16'd7, 1, '1, '0, 0);
    chk("R3 branch retires", retPc[10], 40);
    chk("R3 target follows", retPc[11], 72);
    chk("R3 gap", retCyc[11] - retCyc[10], 4);
    chk("R2 target 40+7", resTgt, 72);
    chk("R4 kills at resolve", resKills, 3'b111);
    chk("R4 no hold in squash mode", holdCnt, 0);
  endtask

  task automatic testNullifyNotTaken();
    runProg(0, 40, 16'd7, 0, '1, '0, 0);
    chk("R5 next retires", retPc[11], 44);
    chk("R5 gap", retCyc[11] - retCyc[10], 1);
    chk("R5 second gap", retCyc[12] - retCyc[11], 1);
    chk("R5 no redirect", tgtCnt + fallCnt + holdCnt, 0);
  endtask

  task automatic testStallTaken();
    runProg(1, 40, 16'd7, 1, '1, '0, 0);
    chk("R7 taken target", retPc[11], 72);
    chk("R7 taken gap", retCyc[11] - retCyc[10], 4);
    chk("R6 hold cycles", holdCnt, 2);
    chk("R4 stall kills", resKills, 3'b111);
  endtask

  task automatic testStallNotTaken();
    runProg(1, 40, 16'd7, 0, '1, '0, 0);
    chk("R7 fall-through", retPc[11], 44);
    chk("R7 fall gap", retCyc[11] - retCyc[10], 4);
    chk("R7 fall select", fallCnt, 1);
    chk("R7 no target", tgtCnt, 0);
    chk("R6 hold cycles nt", holdCnt, 2);
  endtask

  task automatic testBackToBackTaken();
    runProg(0, 40, 16'd7, 1, 44, 16'd100, 1);
    chk("R9 older wins", retPc[11], 72);
    chk("R9 older gap", retCyc[11] - retCyc[10], 4);
    chk("R8 squashed branch inert", tgtCnt, 1);
    chk("R9 after target", retPc[12], 76);
  endtask

  task automatic testOlderNotTaken();
    runProg(0, 40, 16'd7, 0, 44, 16'd7, 1);
    chk("R9 younger retires", retPc[11], 44);
    chk("R9 younger gap", retCyc[11] - retCyc[10], 1);
    chk("R9 younger target", retPc[12], 76);
    chk("R9 younger target gap", retCyc[12] - retCyc[11], 4);
    chk("R2 target 44+7", resTgt, 76);
  endtask

  task automatic testNegativeOffset();
    runProg(0, 60, 16'hFFFB, 1, '1, '0, 0);
    chk("R2 branch 60 retires", retPc[15], 60);
    chk("R2 backward target", retPc[16], 44);
    chk("R2 target 60-5", resTgt, 44);
  endtask

  task automatic testStallBackToBack();
    runProg(1, 40, 16'd7, 1, 72, 16'd3, 0);
    chk("R9 stall first", retPc[11], 72);
    chk("R9 stall first gap", retCyc[11] - retCyc[10], 4);
    chk("R9 stall second", retPc[12], 76);
    chk("R9 stall second gap", retCyc[12] - retCyc[11], 4);
    chk("R6 stall holds", holdCnt, 4);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testNullifyTaken();
    testNullifyNotTaken();
    testStallTaken();
    testStallNotTaken();
    testBackToBackTaken();
    testOlderNotTaken();
    testNegativeOffset();
    testStallBackToBack();
    finish();
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish();
    end
  end

endmodule